// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-facing register side of a two-channel asynchronous serial controller. A processor reaches it over a byte-wide bus with an address, a read strobe and a write strobe. Each channel offers a control port and a data port. The control port reaches sixteen configuration (write) registers and a small set of status (read) registers through an index pointer. After each register access the pointer falls back to zero. Pointer writes also carry embedded commands, and writes to index 9 can reset either channel or both.

On the line side, each channel presents an accepted transmit byte with a one-cycle valid pulse. It takes received bytes through a valid/ready handshake and watches a break input. The interrupt requests of the two channels are ORed and registered onto a single interrupt output. Baud timing, shift registers and buffering beyond one byte in each direction belong to other blocks.

Top module: `dual_serial_regif`

## Requirements
- R1: `bus_addr[2]` picks the channel and `bus_addr[1]` picks the control port (0) or the data port (1). `bus_addr[0]` is ignored.
- R2: A control write while the pointer is 0 loads the pointer from data bits 2:0. If data bits 5:3 are 001, the pointer becomes 8 plus data bits 2:0, which reaches the upper bank.
- R3: In a pointer-0 control write, code 100 in bits 5:3 clears receive-pending and code 101 clears transmit-pending. Any other code, for example 010, changes no pending flag.
- R4: A control write while the pointer is nonzero stores the byte in configuration register n (the pointer value, n not 9) and returns the pointer to 0.
- R5: A control read returns status register n and returns the pointer to 0. Status register 0 has bit 0 = received byte waiting and bit 7 = break seen. Status register 1 reads 0x06. Status registers 2 to 15 read 0.
- R6: A control write at pointer 9 decodes bits 7:6: 00 has no effect, 01 resets channel 1, 10 resets channel 0, 11 resets both. The writing channel's pointer returns to 0.
- R7: A hardware or software reset clears the pointer, both holding bytes and both pending flags. It loads configuration registers 4=0x04, 9=0xC0, 11=0x08, 14=0x30 and 15=0xF8, with the rest at 0. Status register 0 then reads 0x44.
- R8: A data write is taken only when configuration register 5 bit 3 is set. When taken, the byte appears on `tx_byte` with a `tx_valid` pulse in the next cycle, and transmit-pending is set.
- R9: `rx_ready` is high when configuration register 3 bit 0 is set and status bit 0 is clear. A byte is taken on an edge where valid and ready are both high; that edge sets status bit 0 and receive-pending. A data read returns the stored byte and clears status bit 0.
- R10: `brk_in` high at an edge sets status register 0 bit 7 until reset. It leaves the stored receive byte unchanged.
- R11: A channel requests an interrupt when configuration register 1 bit 0 is set and at least one source holds: bit 1 with transmit-pending; bits 4:3 equal to 01 or 10 with receive-pending; or configuration register 15 bit 7 with status bit 7.
- R12: `irq` is the OR of both channel requests, registered, so it follows a state change one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Bus address (bit 2 channel, bit 1 port select) |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port, combinational |
| tx_byte | output | 16 | Transmit holding byte, channel c at [8c+7:8c] |
| tx_valid | output | 2 | One-cycle pulse per channel for a new transmit byte |
| rx_byte | input | 16 | Receive byte, channel c at [8c+7:8c] |
| rx_valid | input | 2 | Receive byte offered, per channel |
| rx_ready | output | 2 | Channel can accept a received byte |
| brk_in | input | 2 | Break indication per channel |
| irq | output | 1 | Shared registered interrupt request |

## Verification
The bench builds the block with its default parameters: two channels, sixteen registers per bank and byte-wide data. Two channels make the cross-channel software resets reachable, including a reset issued from one channel against the other. Sixteen registers per bank put configuration register 15 behind the bank-high pointer command, so that command is checked through the break interrupt enable it controls. Interrupt timing is checked on both sides of the one-cycle register delay.

// File: rtl/serregif_pkg.sv
package serregif_pkg;

  parameter int BYTE_W   = 8;
  parameter int NUM_REGS = 16;
  parameter int NUM_CH   = 2;

  localparam int PTR_W  = $clog2(NUM_REGS);
  localparam int SEL_W  = PTR_W - 1;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int ADDR_W = 2 + CH_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PTR_W-1:0]  ptr_t;

  // embedded command codes carried in bits 5:3 of a pointer write
  localparam logic [2:0] CMD_BANK_HI = 3'b001;
  localparam logic [2:0] CMD_RX_ACK  = 3'b100;
  localparam logic [2:0] CMD_TX_ACK  = 3'b101;

  localparam ptr_t IDX_RESET = ptr_t'(9);

  localparam byte_t STAT0_INIT = 8'h44;
  localparam byte_t STAT1_CONST = 8'h06;

  function automatic byte_t cfg_init(input int idx);
    case (idx)
      4:       return 8'h04;
      9:       return 8'hC0;
      11:      return 8'h08;
      14:      return 8'h30;
      15:      return 8'hF8;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/serregif_busdec.sv
module serregif_busdec
  import serregif_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     wr,
  input  logic                     rd,
  input  logic [NUM_CH*BYTE_W-1:0] ctl_rdata,
  input  logic [NUM_CH*BYTE_W-1:0] dat_rdata,
  output logic [NUM_CH-1:0]        ctl_wr,
  output logic [NUM_CH-1:0]        ctl_rd,
  output logic [NUM_CH-1:0]        dat_wr,
  output logic [NUM_CH-1:0]        dat_rd,
  output byte_t                    rdata
);

  logic [CH_W-1:0] ch_sel;
  logic            is_data;
  logic            unused_addr_lsb;

  assign ch_sel          = addr[ADDR_W-1 -: CH_W];
  assign is_data         = addr[1];
  assign unused_addr_lsb = addr[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_strobe
    logic hit;
    assign hit       = (ch_sel == CH_W'(c));
    assign ctl_wr[c] = hit & wr & ~is_data;
    assign ctl_rd[c] = hit & rd & ~is_data;
    assign dat_wr[c] = hit & wr &  is_data;
    assign dat_rd[c] = hit & rd &  is_data;
  end

  always_comb begin
    if (is_data) rdata = dat_rdata[ch_sel*BYTE_W +: BYTE_W];
    else         rdata = ctl_rdata[ch_sel*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/serregif_chan.sv
module serregif_chan
  import serregif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  byte_t             wdata,
  output byte_t             ctl_rdata,
  output byte_t             dat_rdata,
  output byte_t             tx_byte,
  output logic              tx_valid,
  input  byte_t             rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              brk_in,
  output logic              int_req,
  output logic [NUM_CH-1:0] rst_req
);

  ptr_t  ptr_q, ptr_d;
  byte_t cfg_q [NUM_REGS];
  byte_t stat0_q, stat0_d;
  byte_t rxh_q, rxh_d;
  byte_t txh_q, txh_d;
  logic  txv_q, txv_d;
  logic  txp_q, txp_d;
  logic  rxp_q, rxp_d;
  logic  cfg_we;
  logic  rx_take;
  logic  tx_take;
  logic [2:0] cmd;
  logic  rx_mode_on;
  byte_t unused_cfg_fold;

  assign cmd      = wdata[5:3];
  assign rx_ready = cfg_q[3][0] & ~stat0_q[0];
  assign rx_take  = rx_valid & rx_ready;
  assign tx_take  = dat_wr & cfg_q[5][3];
  assign cfg_we   = ctl_wr & (ptr_q != '0) & (ptr_q != IDX_RESET);

  // software reset requests: bit 7 targets channel 0, bit 6 channel 1
  for (genvar k = 0; k < NUM_CH; k++) begin : g_rreq
    assign rst_req[k] = ctl_wr & (ptr_q == IDX_RESET) & wdata[BYTE_W-1-k];
  end

  // next-state logic
  always_comb begin
    ptr_d   = ptr_q;
    stat0_d = stat0_q;
    rxh_d   = rxh_q;
    txh_d   = txh_q;
    txv_d   = 1'b0;
    txp_d   = txp_q;
    rxp_d   = rxp_q;
    if (ctl_wr) begin
      if (ptr_q == '0) begin
        ptr_d = {1'b0, wdata[SEL_W-1:0]};
        case (cmd)
          CMD_BANK_HI: ptr_d = {1'b1, wdata[SEL_W-1:0]};
          CMD_RX_ACK:  rxp_d = 1'b0;
          CMD_TX_ACK:  txp_d = 1'b0;
          default:     ;
        endcase
      end else begin
        ptr_d = '0;
      end
    end else if (ctl_rd) begin
      ptr_d = '0;
    end
    if (tx_take) begin
      txh_d = wdata;
      txv_d = 1'b1;
      txp_d = 1'b1;
    end
    if (dat_rd) stat0_d[0] = 1'b0;
    if (rx_take) begin
      rxh_d      = rx_byte;
      stat0_d[0] = 1'b1;
      rxp_d      = 1'b1;
    end
    if (brk_in) stat0_d[BYTE_W-1] = 1'b1;
  end

  // state registers: async reset, synchronous software reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      stat0_q <= STAT0_INIT;
      rxh_q   <= '0;
      txh_q   <= '0;
      txv_q   <= 1'b0;
      txp_q   <= 1'b0;
      rxp_q   <= 1'b0;
    end else if (soft_rst) begin
      ptr_q   <= '0;
      stat0_q <= STAT0_INIT;
      rxh_q   <= '0;
      txh_q   <= '0;
      txv_q   <= 1'b0;
      txp_q   <= 1'b0;
      rxp_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      stat0_q <= stat0_d;
      rxh_q   <= rxh_d;
      txh_q   <= txh_d;
      txv_q   <= txv_d;
      txp_q   <= txp_d;
      rxp_q   <= rxp_d;
    end
  end

  // configuration register file with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) cfg_q[i] <= cfg_init(i);
    end else if (soft_rst) begin
      for (int i = 0; i < NUM_REGS; i++) cfg_q[i] <= cfg_init(i);
    end else if (cfg_we) begin
      cfg_q[ptr_q] <= wdata;
    end
  end

  always_comb begin
    unused_cfg_fold = '0;
    for (int i = 0; i < NUM_REGS; i++) unused_cfg_fold ^= cfg_q[i];
  end

  // read paths
  always_comb begin
    case (ptr_q)
      ptr_t'(0): ctl_rdata = stat0_q;
      ptr_t'(1): ctl_rdata = STAT1_CONST;
      default:   ctl_rdata = '0;
    endcase
  end
  assign dat_rdata = rxh_q;
  assign tx_byte   = txh_q;
  assign tx_valid  = txv_q;

  // interrupt request
  assign rx_mode_on = (cfg_q[1][4:3] == 2'b01) | (cfg_q[1][4:3] == 2'b10);
  assign int_req = cfg_q[1][0] &
                   ((cfg_q[1][1] & txp_q) |
                    (rx_mode_on & rxp_q) |
                    (cfg_q[15][7] & stat0_q[BYTE_W-1]));

  assert_ptr_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rd && !ctl_wr) |=> (ptr_q == '0));

  assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(dat_wr));

  assert_rx_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !soft_rst) |=> (stat0_q[0] && rxp_q));

  assert_brk_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in && !soft_rst) |=> stat0_q[BYTE_W-1]);

  assert_soft_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ptr_q == '0 && !txp_q && !rxp_q && stat0_q == STAT0_INIT));

endmodule

// File: rtl/serregif_irqcomb.sv
module serregif_irqcomb
  import serregif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  output logic              irq
);

  logic irq_q, irq_d;

  assign irq_d = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;

  assert_irq_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|req)));

endmodule

// File: rtl/dual_serial_regif.sv
module dual_serial_regif
  import serregif_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [BYTE_W-1:0]        bus_wdata,
  output logic [BYTE_W-1:0]        bus_rdata,
  output logic [NUM_CH*BYTE_W-1:0] tx_byte,
  output logic [NUM_CH-1:0]        tx_valid,
  input  logic [NUM_CH*BYTE_W-1:0] rx_byte,
  input  logic [NUM_CH-1:0]        rx_valid,
  output logic [NUM_CH-1:0]        rx_ready,
  input  logic [NUM_CH-1:0]        brk_in,
  output logic                     irq
);

  logic [NUM_CH-1:0]        ctl_wr, ctl_rd, dat_wr, dat_rd;
  logic [NUM_CH*BYTE_W-1:0] ctl_rdata, dat_rdata;
  logic [NUM_CH-1:0]        int_req;
  logic [NUM_CH-1:0]        soft_rst;
  logic [NUM_CH*NUM_CH-1:0] rst_req;

  serregif_busdec u_busdec (
    .addr      (bus_addr),
    .wr        (bus_wr),
    .rd        (bus_rd),
    .ctl_rdata (ctl_rdata),
    .dat_rdata (dat_rdata),
    .ctl_wr    (ctl_wr),
    .ctl_rd    (ctl_rd),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .rdata     (bus_rdata)
  );

  // a reset written on any channel may target any channel
  always_comb begin
    soft_rst = '0;
    for (int src = 0; src < NUM_CH; src++) begin
      for (int dst = 0; dst < NUM_CH; dst++) begin
        soft_rst[dst] = soft_rst[dst] | rst_req[src*NUM_CH + dst];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    serregif_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst[c]),
      .ctl_wr    (ctl_wr[c]),
      .ctl_rd    (ctl_rd[c]),
      .dat_wr    (dat_wr[c]),
      .dat_rd    (dat_rd[c]),
      .wdata     (bus_wdata),
      .ctl_rdata (ctl_rdata[c*BYTE_W +: BYTE_W]),
      .dat_rdata (dat_rdata[c*BYTE_W +: BYTE_W]),
      .tx_byte   (tx_byte[c*BYTE_W +: BYTE_W]),
      .tx_valid  (tx_valid[c]),
      .rx_byte   (rx_byte[c*BYTE_W +: BYTE_W]),
      .rx_valid  (rx_valid[c]),
      .rx_ready  (rx_ready[c]),
      .brk_in    (brk_in[c]),
      .int_req   (int_req[c]),
      .rst_req   (rst_req[c*NUM_CH +: NUM_CH])
    );
  end

  serregif_irqcomb u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (int_req),
    .irq   (irq)
  );

  assert_one_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_wr | dat_wr));

endmodule

// File: tb/tb_dual_serial_regif.sv
module tb_dual_serial_regif;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [15:0] tx_byte, rx_byte;
  logic [1:0]  tx_valid, rx_valid, rx_ready, brk_in;
  logic        irq;

  int nchk  = 0;
  int nfail = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  dual_serial_regif dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .brk_in(brk_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ctl_w(input int ch, input logic [7:0] d);
    bus_write(3'(ch * 4), d);
  endtask

  task automatic wreg(input int ch, input int n, input logic [7:0] d);
    if (n >= 8) ctl_w(ch, 8'h08 | 8'(n - 8));
    else        ctl_w(ch, 8'(n));
    ctl_w(ch, d);
  endtask

  task automatic rstat(input int ch, input int n, output logic [7:0] d);
    if (n != 0) begin
      if (n >= 8) ctl_w(ch, 8'h08 | 8'(n - 8));
      else        ctl_w(ch, 8'(n));
    end
    bus_read(3'(ch * 4), d);
  endtask

  task automatic rx_send(input int ch, input logic [7:0] b);
    @(negedge clk);
    rx_byte[ch*8 +: 8] = b; rx_valid[ch] = 1'b1;
    @(negedge clk);
    rx_valid[ch] = 1'b0;
  endtask

  task automatic brk_pulse(input int ch);
    @(negedge clk);
    brk_in[ch] = 1'b1;
    @(negedge clk);
    brk_in[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R7 irq after reset", irq, 0);
    chk("R7 tx_valid after reset", tx_valid, 0);
    chk("R9 rx_ready with receiver off", rx_ready, 0);
    rstat(0, 0, rv); chk("R7 ch0 status0 reset", rv, 8'h44);
    rstat(1, 0, rv); chk("R7 ch1 status0 reset", rv, 8'h44);
    rstat(1, 1, rv); chk("R5 status1 constant", rv, 8'h06);
    rstat(0, 2, rv); chk("R5 status2 zero", rv, 8'h00);
    bus_read(3'd2, rv); chk("R7 rx holding cleared", rv, 8'h00);
  endtask

  task automatic t_tx;
    bus_write(3'd2, 8'h5A);
    chk("R8 write ignored with tx disabled", tx_valid, 2'b00);
    wreg(0, 5, 8'h08);
    bus_write(3'd3, 8'hA5);
    chk("R1 R8 tx pulse on ch0 via addr 3", tx_valid, 2'b01);
    chk("R8 tx byte", tx_byte[7:0], 8'hA5);
    @(negedge clk);
    chk("R8 tx pulse one cycle", tx_valid, 2'b00);
    bus_write(3'd6, 8'h11);
    chk("R1 ch1 tx still disabled", tx_valid, 2'b00);
  endtask

  task automatic t_txirq;
    wreg(0, 1, 8'h01);
    @(negedge clk);
    chk("R11 tx pending without tx enable", irq, 0);
    wreg(0, 1, 8'h03);
    chk("R12 irq not yet updated", irq, 0);
    @(negedge clk);
    chk("R11 R12 tx interrupt", irq, 1);
    ctl_w(0, 8'h28);
    @(negedge clk);
    chk("R3 tx pending cleared", irq, 0);
    wreg(0, 1, 8'h00);
  endtask

  task automatic t_rx;
    wreg(1, 3, 8'h01);
    chk("R4 R9 ready after enabling", rx_ready, 2'b10);
    rx_send(1, 8'h3C);
    chk("R9 ready drops when full", rx_ready, 2'b00);
    rx_send(1, 8'h99);
    rstat(1, 0, rv); chk("R9 status0 byte waiting", rv, 8'h45);
    wreg(1, 1, 8'h19);
    @(negedge clk);
    chk("R11 rx mode 11 gives no interrupt", irq, 0);
    wreg(1, 1, 8'h09);
    @(negedge clk);
    chk("R11 rx interrupt", irq, 1);
    ctl_w(1, 8'h10);
    @(negedge clk);
    chk("R3 code 010 no effect", irq, 1);
    ctl_w(1, 8'h20);
    @(negedge clk);
    chk("R3 rx pending cleared", irq, 0);
    bus_read(3'd6, rv); chk("R9 data read returns first byte", rv, 8'h3C);
    rstat(1, 0, rv); chk("R9 status0 bit0 cleared", rv, 8'h44);
    chk("R9 ready again", rx_ready, 2'b10);
    wreg(1, 1, 8'h00);
  endtask

  task automatic t_brk;
    brk_pulse(0);
    rstat(0, 0, rv); chk("R10 break flag", rv, 8'hC4);
    bus_read(3'd2, rv); chk("R10 rx byte unchanged", rv, 8'h00);
    wreg(0, 1, 8'h01);
    @(negedge clk);
    chk("R11 break interrupt", irq, 1);
    ctl_w(0, 8'h0F);
    ctl_w(0, 8'h00);
    @(negedge clk);
    chk("R2 bank-high pointer reaches reg 15", irq, 0);
    rstat(0, 0, rv); chk("R4 pointer home after store", rv, 8'hC4);
    ctl_w(0, 8'h01);
    bus_read(3'd0, rv); chk("R5 read status1", rv, 8'h06);
    bus_read(3'd0, rv); chk("R5 pointer home after read", rv, 8'hC4);
  endtask

  task automatic t_soft;
    rx_send(1, 8'h77);
    wreg(0, 9, 8'h00);
    rstat(0, 0, rv); chk("R6 code 00 keeps ch0", rv, 8'hC4);
    rstat(1, 0, rv); chk("R6 code 00 keeps ch1", rv, 8'h45);
    wreg(1, 9, 8'h80);
    rstat(0, 0, rv); chk("R6 code 10 resets ch0", rv, 8'h44);
    rstat(1, 0, rv); chk("R6 ch1 kept, its pointer home", rv, 8'h45);
    bus_write(3'd2, 8'h33);
    chk("R7 ch0 tx enable cleared", tx_valid, 2'b00);
    wreg(0, 9, 8'h40);
    rstat(1, 0, rv); chk("R6 code 01 resets ch1", rv, 8'h44);
    bus_read(3'd6, rv); chk("R7 ch1 rx holding cleared", rv, 8'h00);
    chk("R7 ch1 receiver disabled", rx_ready, 2'b00);
    wreg(0, 5, 8'h08);
    wreg(1, 5, 8'h08);
    wreg(1, 9, 8'hC0);
    bus_write(3'd2, 8'h44);
    chk("R6 both reset ch0 tx", tx_valid, 2'b00);
    bus_write(3'd6, 8'h44);
    chk("R6 both reset ch1 tx", tx_valid, 2'b00);
    brk_pulse(0);
    wreg(0, 1, 8'h01);
    @(negedge clk);
    chk("R7 break enable restored", irq, 1);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; rx_byte = '0; rx_valid = '0; brk_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx();
    t_txirq();
    t_rx();
    t_brk();
    t_soft();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule